// File: doc/BRIEF.md
# Staggered Channel Switching Sequencer

This block spreads the switching of sixteen output channels over time so they do not all change in the same instant. Each channel has a request bit. The request is the channel's latched on/off bit, forced off while the global blanking input is high or the thermal-disable input is high. The request is registered once. After that, channel n's drive output repeats its request n × `DELAY_CYCLES` clocks later. Channel 0 has no added delay. The same spacing applies when a channel turns on and when it turns off.

Gating is applied before the delay. A change on blanking or thermal-disable therefore ripples across the channels in the same progressive way as a data change. Every channel has its own shift chain. Because of that, a request edge is never dropped, merged or reordered, even when it is shorter than the channel's delay.

A small state machine reports when the ripple has finished, so open-load sampling can be timed after it. It has two states. `ST_SETTLED` is the reset state and drives `settled` high. `ST_RIPPLE` drives `settled` low. The transitions are:

- settle-to-ripple: taken when the registered request takes a new value.
- ripple-restart: taken when another request change arrives while rippling. It reloads the countdown.
- ripple-to-settle: taken when the countdown of (NUM_CH-1) × `DELAY_CYCLES` clocks expires with no new change.

Top module: `stagger_seq`

## Requirements
- R1: While reset is held and right after it, every `drive` bit is 0 and `settled` is 1.
- R2: The registered request for channel c is `on_bits[c] & ~blank & ~thermal_off`, captured at a rising clock edge. `drive[0]` shows the value captured at the previous edge, so it follows one clock after the inputs change.
- R3: When a channel's request goes from 0 to 1, `drive[n]` rises c × `DELAY_CYCLES` clocks after `drive[0]` would, where c is the channel index n. This holds for any mix of channels changing together.
- R4: When a request goes from 1 to 0, `drive[n]` falls after the same n × `DELAY_CYCLES` clock offset as in R3.
- R5: While `blank` is 1, every request is 0, whatever `on_bits` holds. Changes on `on_bits` during blanking never reach `drive`. The blanking edges themselves ripple across the channels as in R3/R4.
- R6: While `thermal_off` is 1, every request is 0, whatever `on_bits` holds. Its edges ripple across the channels in the same way.
- R7: `settled` goes to 0 at the edge that captures a changed request. It returns to 1 exactly (NUM_CH-1) × `DELAY_CYCLES` clocks after the last such change. Further changes during the ripple restart the wait.
- R8: Whenever `settled` is 1, every `drive` bit equals its current registered request. A request pulse of one clock reaches every channel as a one-clock pulse, shifted by that channel's delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_bits | input | NUM_CH | Latched per-channel on/off bits, 1 = on |
| blank | input | 1 | Global blanking, 1 forces all requests off |
| thermal_off | input | 1 | Thermal disable, 1 forces all requests off |
| drive | output | NUM_CH | Staggered per-channel drive, 1 = sinking |
| settled | output | 1 | 1 when all drives match their requests |

## Verification
The bench keeps its own delay-line model built from the requirements. It compares every channel and the settle flag on every clock.

- Alternating turn-on and turn-off patterns catch a design that delays only one edge direction, or that indexes the taps in reverse. Such a design lights the high channels first.
- A one-clock pulse on all channels catches a chain that loses short edges. One that drops the pulse leaves a channel dark; one that stretches it keeps a channel on for extra clocks.
- Changes during blanking or thermal disable catch gating placed after the delay. That design would switch every channel at once instead of rippling them.
- Back-to-back changes within one ripple window catch a settle flag that does not restart its wait. That design would report settled while the high channels are still moving.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

    typedef enum logic [0:0] {
        ST_SETTLED = 1'b0,
        ST_RIPPLE  = 1'b1
    } settle_state_e;

    function automatic int settle_span(input int num_ch, input int unit);
        return (num_ch - 1) * unit;
    endfunction

endpackage

// File: rtl/stagger_req_gate.sv
module stagger_req_gate #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] on_bits,
    input  logic              blank,
    input  logic              thermal_off,
    output logic [NUM_CH-1:0] req_next,
    output logic [NUM_CH-1:0] req_q
);

    logic force_off;

    always_comb begin
        force_off = blank | thermal_off;
        req_next  = force_off ? '0 : on_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_next;
        end
    end

    // R5: blanking empties the captured request
    p_blank_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blank) |-> (req_q == '0));

    // R6: thermal disable empties the captured request
    p_thermal_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(thermal_off) |-> (req_q == '0));

endmodule

// File: rtl/stagger_tap_chain.sv
module stagger_tap_chain #(
    parameter int NUM_CH       = 16,
    parameter int DELAY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_q,
    output logic [NUM_CH-1:0] drive
);

    assign drive[0] = req_q[0];

    for (genvar ch = 1; ch < NUM_CH; ch++) begin : g_ch
        localparam int LEN = ch * DELAY_CYCLES;
        logic [LEN-1:0] sr;

        if (LEN == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sr <= '0;
                end else begin
                    sr <= req_q[ch];
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sr <= '0;
                end else begin
                    sr <= {sr[LEN-2:0], req_q[ch]};
                end
            end
        end

        assign drive[ch] = sr[LEN-1];
    end

endmodule

// File: rtl/stagger_settle_fsm.sv
module stagger_settle_fsm
    import stagger_pkg::*;
#(
    parameter int NUM_CH       = 16,
    parameter int DELAY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_next,
    input  logic [NUM_CH-1:0] req_q,
    input  logic [NUM_CH-1:0] drive,
    output logic              settled
);

    localparam int SPAN  = settle_span(NUM_CH, DELAY_CYCLES);
    localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SPAN - 1);

    settle_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             change;

    assign change = (req_next != req_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SETTLED: begin
                if (change) begin
                    state_d = ST_RIPPLE;
                    cnt_d   = RELOAD;
                end
            end
            ST_RIPPLE: begin
                if (change) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_SETTLED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_SETTLED;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        settled = (state_q == ST_SETTLED);
    end

    // R7: a newly captured request always drops the settle flag
    p_change_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> !settled);

    // R8: settled means the delay chains have caught up
    p_settle_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (drive == req_q));

endmodule

// File: rtl/stagger_seq.sv
module stagger_seq #(
    parameter int NUM_CH       = 16,
    parameter int DELAY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] on_bits,
    input  logic              blank,
    input  logic              thermal_off,
    output logic [NUM_CH-1:0] drive,
    output logic              settled
);

    logic [NUM_CH-1:0] req_next;
    logic [NUM_CH-1:0] req_q;
    logic              past_ok;

    stagger_req_gate #(
        .NUM_CH(NUM_CH)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_bits    (on_bits),
        .blank      (blank),
        .thermal_off(thermal_off),
        .req_next   (req_next),
        .req_q      (req_q)
    );

    stagger_tap_chain #(
        .NUM_CH      (NUM_CH),
        .DELAY_CYCLES(DELAY_CYCLES)
    ) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .req_q(req_q),
        .drive(drive)
    );

    stagger_settle_fsm #(
        .NUM_CH      (NUM_CH),
        .DELAY_CYCLES(DELAY_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_next(req_next),
        .req_q   (req_q),
        .drive   (drive),
        .settled (settled)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R2: channel 0 trails the gated inputs by exactly one clock
    p_ch0_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (drive[0] == $past(on_bits[0] & ~blank & ~thermal_off)));

    // R1: nothing is driven straight out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (drive == '0 && settled));

endmodule

// File: tb/stagger_seq_tb.sv
module stagger_seq_tb_top;

    localparam int  NUM_CH  = 16;
    localparam int  DLY     = 2;
    localparam int  SPAN    = (NUM_CH - 1) * DLY;
    localparam int  HDEPTH  = SPAN + 1;
    localparam time CLK_P   = 8ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] on_bits = '0;
    logic              blank = 1'b0;
    logic              thermal_off = 1'b0;
    logic [NUM_CH-1:0] drive;
    logic              settled;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NUM_CH-1:0] hist [HDEPTH];
    int since;

    always #(CLK_P/2) clk = ~clk;

    stagger_seq #(.NUM_CH(NUM_CH), .DELAY_CYCLES(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .on_bits(on_bits), .blank(blank),
        .thermal_off(thermal_off), .drive(drive), .settled(settled)
    );

    function automatic logic [NUM_CH-1:0] gated();
        return (blank | thermal_off) ? '0 : on_bits;
    endfunction

    function automatic logic [NUM_CH-1:0] exp_drive();
        logic [NUM_CH-1:0] e;
        for (int c = 0; c < NUM_CH; c++) e[c] = hist[c*DLY][c];
        return e;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < HDEPTH; i++) hist[i] = '0;
        since = SPAN;
    endtask

    // one clock: update the model with the inputs seen at the edge, then compare
    task automatic step(input string tag);
        logic [NUM_CH-1:0] e;
        logic es;
        @(negedge clk);
        for (int i = HDEPTH-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = gated();
        if (hist[0] != hist[1]) since = 0;
        else if (since < SPAN) since++;
        e  = exp_drive();
        es = (since >= SPAN);
        n_vec++;
        if (drive !== e) begin
            n_fail++;
            $display("FAIL %s drive got %h exp %h", tag, drive, e);
        end
        n_vec++;
        if (settled !== es) begin
            n_fail++;
            $display("FAIL R7 settled got %b exp %b (%s)", settled, es, tag);
        end
        if (es) begin
            n_vec++;
            if (drive !== hist[0]) begin
                n_fail++;
                $display("FAIL R8 drive got %h exp %h while settled", drive, hist[0]);
            end
        end
    endtask

    task automatic run(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) step(tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        on_bits = 16'hFFFF;
        model_clear();
        repeat (3) @(negedge clk);
        n_vec++;
        if (drive !== '0 || settled !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 drive=%h settled=%b exp 0000/1", drive, settled);
        end
        on_bits = '0;
        @(negedge clk);
        rst_n = 1'b1;
        run(3, "R1");
    endtask

    task automatic t_ch0();
        on_bits = 16'h0001; run(4, "R2");
        on_bits = 16'h0000; run(4, "R2");
    endtask

    task automatic t_turn_on();
        on_bits = 16'hFFFF; run(SPAN + 4, "R3");
    endtask

    task automatic t_turn_off();
        on_bits = 16'h0000; run(SPAN + 4, "R4");
    endtask

    task automatic t_pattern();
        on_bits = 16'hA5A5; run(SPAN + 3, "R3");
        on_bits = 16'h5A5A; run(SPAN + 3, "R4");
        on_bits = 16'h0000; run(SPAN + 3, "R4");
    endtask

    task automatic t_blank();
        on_bits = 16'hFFFF; run(SPAN + 2, "R5");
        blank = 1'b1;       run(6, "R5");
        on_bits = 16'h1234; run(3, "R5");
        on_bits = 16'hFFFF; run(SPAN + 2, "R5");
        blank = 1'b0;       run(SPAN + 2, "R5");
    endtask

    task automatic t_thermal();
        thermal_off = 1'b1; run(4, "R6");
        on_bits = 16'h0F0F; run(SPAN + 2, "R6");
        thermal_off = 1'b0; run(SPAN + 2, "R6");
        on_bits = 16'h0000; run(SPAN + 2, "R6");
    endtask

    task automatic t_pulse();
        on_bits = 16'hFFFF; run(1, "R8");
        on_bits = 16'h0000; run(SPAN + 3, "R8");
    endtask

    task automatic t_settle();
        on_bits = 16'h00FF; run(5, "R7");
        on_bits = 16'hFF00; run(5, "R7");
        on_bits = 16'h8001; run(SPAN - 1, "R7");
        on_bits = 16'h8000; run(SPAN + 3, "R7");
        on_bits = 16'h0000; run(SPAN + 3, "R7");
    endtask

    initial begin
        t_reset();
        t_ch0();
        t_turn_on();
        t_turn_off();
        t_pattern();
        t_blank();
        t_thermal();
        t_pulse();
        t_settle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule